// File: doc/BRIEF.md
# Per-Channel Tristate Control Serializer

This block produces four serial control lines that tell external bus drivers when each channel of sixteen time-division-multiplexed backplane output streams must be released to high impedance. Every stream carries 512 channels per frame. The block reads each channel's output-enable bit from a four-bit-wide connection-memory read port. Each control line carries the bits of four streams, one bit per control-clock period. The whole sequence runs ten periods ahead of the frame boundary, so the first bits of a frame fall at the end of the frame before it.

A frame pulse realigns the internal slot counter. Between pulses the counter keeps running and wraps every 2048 periods. When the backplane runs at its double rate, only the lower eight streams are used. The block then forces the control bits of the upper eight streams to zero, whatever memory holds. It also drives the idle level of those eight unused stream pins: either driven high or high impedance, set by a static select input.

Top module: `tsc_ctl_serializer`

## Requirements
- R1: Line n (0..3) serves streams n, n+4, n+8 and n+12. During an address cycle with group g on `rd_grp_o` and channel c on `rd_chan_o`, `rd_bits_i[n]` returns, one cycle later, the enable bit of stream 4*g+n, channel c.
- R2: Each bit on `ctl_o` is a copy of the enable bit read from memory. A 1 means the channel is driven; a 0 means it is high impedance.
- R3: If `frame_i` is high at a rising edge, the next cycle is 1-based period 1. The bit for channel c of group k appears in 1-based period ((4*c + k - 10) mod 2048) + 1.
- R4: Channel 0 of stream n appears in period 2039. Channel 0 of stream n+12 appears in period 2042 on all four lines. Both positions lie in the frame before the boundary they belong to.
- R5: Channel 511 of stream 4 appears on line 0 in period 2036. Channel 5 of stream 5 appears on line 1 in period 12.
- R6: In the cycle after the frame edge, the read address is channel 3, group 0. The address then steps by one slot per cycle, with the group changing fastest.
- R7: With `half_mode_i`=1, every bit for streams 8..15 (groups 2 and 3) is 0.
- R8: With `half_mode_i`=0, the bits for streams 8..15 follow memory.
- R9: `upper_oe_o` is all ones only when `half_mode_i`=1 and `idle_sel_i`=1. Otherwise it is all zeros. `upper_dat_o` is always all ones.
- R10: While `rst_ni` is low, `ctl_o` is 0, so every channel is released.
- R11: With no frame pulse, the slot counter wraps from period 2048 to period 1 and the mapping of R3 holds in the following frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock, one period per control bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame pulse, one cycle wide, high in the last period of a frame |
| half_mode_i | input | 1 | Static: double-rate backplane, upper streams unused |
| idle_sel_i | input | 1 | Static: idle level of unused stream pins (1 driven high, 0 high impedance) |
| rd_chan_o | output | 9 | Connection-memory read channel index |
| rd_grp_o | output | 2 | Connection-memory read group (stream div 4) |
| rd_bits_i | input | 4 | Enable bits of streams 4*group+n, valid one cycle after the address |
| ctl_o | output | 4 | Serial control lines, one per line group |
| upper_oe_o | output | 8 | Output enable for unused stream pins 8..15 |
| upper_dat_o | output | 8 | Level driven on unused stream pins 8..15 |

## Verification
The hardest case to reach from the ports is the wrap: bits that belong to a frame but are sent in the last ten periods of the previous one. A single frame pulse cannot show them, because the periods just after a realignment still carry slots addressed before it. The bench therefore sends one pulse and lets a whole frame pass to flush the pipeline. It then captures a later frame from the free-running counter. First it plants isolated 1 bits at the named positions in otherwise empty memory. After that it compares full frames of random memory against the mapping, in both rate modes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TSC_LINES    = 4;
  localparam int TSC_GROUP    = 4;
  localparam int TSC_CHANNELS = 512;
  localparam int TSC_ADVANCE  = 10;
  // address cycle -> data return -> output register
  localparam int TSC_PIPE     = 2;
endpackage

// File: rtl/tsc_slot_cnt.sv
module tsc_slot_cnt #(
  parameter int FRAME = 2048,
  parameter int LOAD  = 12,
  localparam int SW   = $clog2(FRAME)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  output logic [SW-1:0] slot_o
);
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       slot_q <= SW'(LOAD);
    else if (frame_i)                  slot_q <= SW'(LOAD);
    else if (slot_q == SW'(FRAME - 1)) slot_q <= '0;
    else                               slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/tsc_addr_map.sv
module tsc_addr_map #(
  parameter int CHANNELS = 512,
  parameter int GROUP    = 4,
  localparam int FRAME   = CHANNELS * GROUP,
  localparam int SW      = $clog2(FRAME),
  localparam int CW      = $clog2(CHANNELS),
  localparam int GW      = $clog2(GROUP)
) (
  input  logic [SW-1:0] slot_i,
  output logic [CW-1:0] chan_o,
  output logic [GW-1:0] grp_o
);
  // group varies fastest within a slot sequence
  assign chan_o = slot_i[SW-1:GW];
  assign grp_o  = slot_i[GW-1:0];
endmodule

// File: rtl/tsc_bit_stage.sv
module tsc_bit_stage #(
  parameter int LINES = 4,
  parameter int GROUP = 4,
  localparam int GW   = $clog2(GROUP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_i,
  input  logic [GW-1:0]    grp_i,
  input  logic [LINES-1:0] bits_i,
  output logic [LINES-1:0] ctl_o
);
  logic [GW-1:0] grp_d;
  logic          kill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_d <= '0;
    else         grp_d <= grp_i;
  end

  // upper groups map to the unused upper half of the streams
  assign kill = half_i && (grp_d >= GW'(GROUP / 2));

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= bits_i[l] & ~kill;
    end
    assign ctl_o[l] = bit_q;
  end
endmodule

// File: rtl/tsc_idle_drv.sv
module tsc_idle_drv #(
  parameter int UPPER = 8
) (
  input  logic             half_i,
  input  logic             sel_i,
  output logic [UPPER-1:0] oe_o,
  output logic [UPPER-1:0] dat_o
);
  for (genvar p = 0; p < UPPER; p++) begin : g_pin
    assign oe_o[p]  = half_i & sel_i;
    assign dat_o[p] = 1'b1;
  end
endmodule

// File: rtl/tsc_ctl_serializer.sv
module tsc_ctl_serializer
  import tsc_pkg::*;
#(
  parameter int LINES    = TSC_LINES,
  parameter int GROUP    = TSC_GROUP,
  parameter int CHANNELS = TSC_CHANNELS,
  parameter int ADVANCE  = TSC_ADVANCE,
  localparam int STREAMS = LINES * GROUP,
  localparam int FRAME   = CHANNELS * GROUP,
  localparam int SW      = $clog2(FRAME),
  localparam int CW      = $clog2(CHANNELS),
  localparam int GW      = $clog2(GROUP),
  localparam int UPPER   = STREAMS / 2,
  localparam int LOAD    = (ADVANCE + TSC_PIPE) % FRAME
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             half_mode_i,
  input  logic             idle_sel_i,
  output logic [CW-1:0]    rd_chan_o,
  output logic [GW-1:0]    rd_grp_o,
  input  logic [LINES-1:0] rd_bits_i,
  output logic [LINES-1:0] ctl_o,
  output logic [UPPER-1:0] upper_oe_o,
  output logic [UPPER-1:0] upper_dat_o
);
  logic [SW-1:0] slot;

  tsc_slot_cnt #(.FRAME(FRAME), .LOAD(LOAD)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .slot_o (slot)
  );

  tsc_addr_map #(.CHANNELS(CHANNELS), .GROUP(GROUP)) u_map (
    .slot_i(slot),
    .chan_o(rd_chan_o),
    .grp_o (rd_grp_o)
  );

  tsc_bit_stage #(.LINES(LINES), .GROUP(GROUP)) u_bits (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .half_i(half_mode_i),
    .grp_i (rd_grp_o),
    .bits_i(rd_bits_i),
    .ctl_o (ctl_o)
  );

  tsc_idle_drv #(.UPPER(UPPER)) u_idle (
    .half_i(half_mode_i),
    .sel_i (idle_sel_i),
    .oe_o  (upper_oe_o),
    .dat_o (upper_dat_o)
  );
endmodule

// File: rtl/tsc_ctl_serializer_chk.sv
module tsc_ctl_serializer_chk
  import tsc_pkg::*;
#(
  parameter int LINES    = TSC_LINES,
  parameter int GROUP    = TSC_GROUP,
  parameter int CHANNELS = TSC_CHANNELS,
  parameter int ADVANCE  = TSC_ADVANCE,
  localparam int STREAMS = LINES * GROUP,
  localparam int FRAME   = CHANNELS * GROUP,
  localparam int SW      = $clog2(FRAME),
  localparam int CW      = $clog2(CHANNELS),
  localparam int GW      = $clog2(GROUP),
  localparam int UPPER   = STREAMS / 2,
  localparam int LOAD    = (ADVANCE + TSC_PIPE) % FRAME
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_i,
  input logic             half_mode_i,
  input logic             idle_sel_i,
  input logic [CW-1:0]    rd_chan_o,
  input logic [GW-1:0]    rd_grp_o,
  input logic [LINES-1:0] rd_bits_i,
  input logic [LINES-1:0] ctl_o,
  input logic [UPPER-1:0] upper_oe_o,
  input logic [UPPER-1:0] upper_dat_o
);
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 1'b1;
  end

  p_frame_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> {rd_chan_o, rd_grp_o} == SW'(LOAD));

  p_slot_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> {rd_chan_o, rd_grp_o} == SW'($past({rd_chan_o, rd_grp_o}) + 1'b1));

  p_half_kill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2 && $past(half_mode_i) && $past(rd_grp_o, 2) >= GW'(GROUP / 2))
      |-> ctl_o == '0);

  p_bit_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2 && !($past(half_mode_i) && $past(rd_grp_o, 2) >= GW'(GROUP / 2)))
      |-> ctl_o == $past(rd_bits_i));

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> ctl_o == '0);

  p_idle_oe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(half_mode_i && idle_sel_i) |-> upper_oe_o == '0);

  p_idle_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upper_oe_o != '0 |-> upper_dat_o == '1);
endmodule

bind tsc_ctl_serializer tsc_ctl_serializer_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .half_mode_i(half_mode_i),
  .idle_sel_i (idle_sel_i),
  .rd_chan_o  (rd_chan_o),
  .rd_grp_o   (rd_grp_o),
  .rd_bits_i  (rd_bits_i),
  .ctl_o      (ctl_o),
  .upper_oe_o (upper_oe_o),
  .upper_dat_o(upper_dat_o)
);

// File: tb/tsc_ctl_serializer_tb_top.sv
`timescale 1ns/1ps
module tsc_ctl_serializer_tb_top;
  localparam int FRAME = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic       half = 1'b0;
  logic       sel = 1'b0;
  logic [8:0] rd_chan;
  logic [1:0] rd_grp;
  logic [3:0] rd_bits = '0;
  logic [3:0] ctl;
  logic [7:0] up_oe, up_dat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic mem [0:15][0:511];
  logic cap [0:3][0:FRAME-1];

  // {stream, channel, 1-based period}
  localparam logic [24:0] VEC [12] = '{
    {4'd0,  9'd0,   12'd2039},  // R4
    {4'd12, 9'd0,   12'd2042},  // R4
    {4'd13, 9'd0,   12'd2042},  // R4
    {4'd14, 9'd0,   12'd2042},  // R4
    {4'd15, 9'd0,   12'd2042},  // R4
    {4'd3,  9'd0,   12'd2039},  // R4
    {4'd4,  9'd511, 12'd2036},  // R5
    {4'd5,  9'd5,   12'd12},    // R5
    {4'd7,  9'd1,   12'd2044},  // R3
    {4'd2,  9'd3,   12'd3},     // R3
    {4'd11, 9'd2,   12'd1},     // R3
    {4'd8,  9'd511, 12'd2037}   // R3
  };

  always #2.5 clk = ~clk;

  tsc_ctl_serializer dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .frame_i    (frame),
    .half_mode_i(half),
    .idle_sel_i (sel),
    .rd_chan_o  (rd_chan),
    .rd_grp_o   (rd_grp),
    .rd_bits_i  (rd_bits),
    .ctl_o      (ctl),
    .upper_oe_o (up_oe),
    .upper_dat_o(up_dat)
  );

  // R1: synchronous memory model, stream = 4*group + line
  always @(posedge clk) begin
    for (int n = 0; n < 4; n++) rd_bits[n] <= mem[4 * int'(rd_grp) + n][rd_chan];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
  endtask

  task automatic skip_frame();
    for (int p = 0; p < FRAME; p++) @(negedge clk);
  endtask

  task automatic capture();
    for (int p = 0; p < FRAME; p++) begin
      for (int n = 0; n < 4; n++) cap[n][p] = ctl[n];
      @(negedge clk);
    end
  endtask

  function automatic logic exp_bit(input int n, input int q, input bit hm);
    int s, c, k;
    s = (q + 10) % FRAME;
    c = s / 4;
    k = s % 4;
    if (hm && k >= 2) return 1'b0;
    return mem[4 * k + n][c];
  endfunction

  task automatic check_frame(input bit hm);
    for (int q = 0; q < FRAME; q++) begin
      for (int n = 0; n < 4; n++) begin
        int k;
        k = (q + 10) % 4;
        if (k >= 2) chk(cap[n][q] == exp_bit(n, q, hm), hm ? "R7" : "R8",
                        int'(cap[n][q]), int'(exp_bit(n, q, hm)));
        else        chk(cap[n][q] == exp_bit(n, q, hm), "R3",
                        int'(cap[n][q]), int'(exp_bit(n, q, hm)));
      end
    end
  endtask

  initial begin
    for (int s = 0; s < 16; s++) for (int c = 0; c < 512; c++) mem[s][c] = 1'b0;
    repeat (3) @(negedge clk);
    chk(ctl == 4'b0, "R10", int'(ctl), 0);
    for (int s = 0; s < 16; s++) for (int c = 0; c < 512; c++) mem[s][c] = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctl == 4'b0, "R10", int'(ctl), 0);
    for (int s = 0; s < 16; s++) for (int c = 0; c < 512; c++) mem[s][c] = 1'b0;
    rst_n = 1'b1;

    // R6: address after the frame edge
    pulse_frame();
    chk(rd_chan == 9'd3 && rd_grp == 2'd0, "R6", int'({rd_chan, rd_grp}), 12);
    @(negedge clk);
    chk(rd_chan == 9'd3 && rd_grp == 2'd1, "R6", int'({rd_chan, rd_grp}), 13);

    // table walk: isolated ones at named positions (R4, R5, R1)
    foreach (VEC[i]) mem[VEC[i][24:21]][VEC[i][20:12]] = 1'b1;
    pulse_frame();
    skip_frame();
    capture();
    for (int i = 0; i < 12; i++) begin
      int st, pr;
      st = int'(VEC[i][24:21]);
      pr = int'(VEC[i][11:0]);
      chk(cap[st % 4][pr - 1] == 1'b1, "R4/R5 R1 position", int'(cap[st % 4][pr - 1]), 1);
    end
    for (int n = 0; n < 4; n++) begin
      int ones, want;
      ones = 0; want = 0;
      for (int p = 0; p < FRAME; p++) ones += int'(cap[n][p]);
      for (int i = 0; i < 12; i++) if (int'(VEC[i][24:21]) % 4 == n) want++;
      chk(ones == want, "R1 line count", ones, want);
    end

    // random memory, full rate; counter free-runs without pulses (R11)
    for (int s = 0; s < 16; s++) for (int c = 0; c < 512; c++) mem[s][c] = 1'($urandom);
    skip_frame();
    capture();
    check_frame(1'b0);
    capture();
    check_frame(1'b0);

    // double-rate mode: upper streams forced to 0 (R7)
    half = 1'b1;
    sel  = 1'b1;
    for (int s = 0; s < 16; s++) for (int c = 0; c < 512; c++) mem[s][c] = 1'($urandom);
    skip_frame();
    capture();
    check_frame(1'b1);

    // R9: idle pin drive
    chk(up_oe == 8'hff, "R9", int'(up_oe), 255);
    chk(up_dat == 8'hff, "R9", int'(up_dat), 255);
    sel = 1'b0; #1;
    chk(up_oe == 8'h00, "R9", int'(up_oe), 0);
    half = 1'b0; sel = 1'b1; #1;
    chk(up_oe == 8'h00, "R9", int'(up_oe), 0);
    chk(up_dat == 8'hff, "R9", int'(up_dat), 255);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule